// File: doc/BRIEF.md
# Pipelined Move-Only Processor Core

This block is a processor with a single operation: copy one memory word to another. An instruction is two adjacent 16-bit words. The word at the even address names where to read, and the word after it names where to write. Four registers (PC, SRC, DST, TMP) advance together on every unfrozen clock, in one step:
- the word in TMP is stored at the address held in DST;
- TMP is reloaded from the address held in SRC;
- SRC and DST are refetched from PC and PC+1;
- PC moves on by two.

Because of this overlap, the value read through one instruction's source word is stored through the next instruction's destination word. Writing to the all-ones destination is not a store but a jump: PC takes the value in TMP. The instruction already fetched behind the jump still runs as a single delay slot.

The core contains a word-addressed memory. It has three combinational read ports for the core, one synchronous write port, and a load/inspect port that a testbench uses to place programs and read back results. Arithmetic is done by devices that the surrounding system maps into memory. A halt input and the load port both freeze the core. Debug outputs show the four registers and the write strobe.

Top module: `movecore_top`

## Requirements
- R1: Synchronous active-high reset clears PC, SRC, DST and TMP to 0. The first two unfrozen steps after reset perform no memory write and no jump.
- R2: On each unfrozen step that is not a taken jump, SRC takes M[PC], DST takes M[PC+1] and PC increases by 2.
- R3: On each unfrozen step, TMP takes M[SRC], where SRC is the value held before that step.
- R4: Once the core is primed, an unfrozen step whose DST is not 16'hFFFF stores TMP at address DST, and dbg_wr is high during that step.
- R5: A word read through instruction N's source address is stored through instruction N+1's destination address. This lets a program compute A = B - C through a memory-mapped subtract location.
- R6: Once the core is primed, an unfrozen step whose DST equals 16'hFFFF writes no memory (dbg_wr low) and loads PC from TMP.
- R7: A taken jump has exactly one delay slot. The instruction at the old PC+2 executes, and the one after it is skipped.
- R8: All reads in a step return memory contents from before that step's write. This applies to the TMP load and to instruction fetch.
- R9: While halt is high, PC, SRC, DST, TMP and the priming state hold, and no memory write occurs.
- R10: While ld_en is high, ld_data is written at ld_addr on the clock edge and the core is frozen as under halt. ld_rdata always shows M[ld_addr] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freezes the core while high |
| ld_en | input | 1 | Load-port write enable; also freezes the core |
| ld_addr | input | 16 | Load/inspect word address |
| ld_data | input | 16 | Word written by the load port |
| ld_rdata | output | 16 | Memory word at ld_addr |
| dbg_pc | output | 16 | Program counter |
| dbg_src | output | 16 | Latched source address |
| dbg_dst | output | 16 | Latched destination address |
| dbg_tmp | output | 16 | Word in flight |
| dbg_wr | output | 1 | Core memory write strobe |

## Verification
A core store and a read of the same word can fall in the same step. The read can be the TMP load or the fetch of the next instruction words. Short programs provoke both cases. In one, an instruction's destination equals its own source, so the store and the TMP load hit the same word. In the other, the destination is the word about to be fetched as the next DST. After that step the bench checks that TMP or DST holds the old word, and reads memory through the inspect port to confirm the new word landed. A second pair is a jump and the delay-slot store. The bench checks these by stepping the core, tracking PC, and confirming that the skipped instruction left no trace in memory.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int WORD_W   = 16;
  localparam int INSN_LEN = 2;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int DW   = mc_pkg::WORD_W,
  parameter int IDXW = 8,
  parameter int NRD  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NRD-1:0][DW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata,
  input  logic                we,
  input  logic [DW-1:0]       waddr,
  input  logic [DW-1:0]       wdata
);
  localparam int DEPTH = 1 << IDXW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr[IDXW-1:0]] <= wdata;
  end

  // Reads are asynchronous and see pre-write contents of the current cycle.
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = store_q[raddr[g][IDXW-1:0]];
  end

  // R4
  wr_land_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> store_q[$past(waddr[IDXW-1:0])] == $past(wdata));
endmodule

// File: rtl/mc_seq.sv
module mc_seq #(
  parameter int DW    = mc_pkg::WORD_W,
  parameter int PRIME = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          freeze,
  input  logic [DW-1:0] dst,
  output logic          primed,
  output logic          wr_stb,
  output logic          take_br
);
  localparam logic [DW-1:0] JUMP_ADDR = '1;

  logic [PRIME-1:0] fill_q;
  logic             is_jump;

  always_ff @(posedge clk) begin
    if (rst)          fill_q <= '0;
    else if (!freeze) fill_q <= {fill_q[PRIME-2:0], 1'b1};
  end

  assign primed  = fill_q[PRIME-1];
  assign is_jump = (dst == JUMP_ADDR);
  assign wr_stb  = primed & ~freeze & ~is_jump;
  assign take_br = primed & ~freeze &  is_jump;

  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(fill_q));
endmodule

// File: rtl/mc_regs.sv
module mc_regs #(
  parameter int DW = mc_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          take_br,
  input  logic [DW-1:0] f_src,
  input  logic [DW-1:0] f_dst,
  input  logic [DW-1:0] m_src,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] src,
  output logic [DW-1:0] dst,
  output logic [DW-1:0] tmp
);
  localparam logic [DW-1:0] STEP = DW'(mc_pkg::INSN_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      src <= '0;
      dst <= '0;
      tmp <= '0;
    end else if (adv) begin
      pc  <= take_br ? tmp : pc + STEP;
      src <= f_src;
      dst <= f_dst;
      tmp <= m_src;
    end
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !take_br) |=> pc == $past(pc) + STEP);

  // R6
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && take_br) |=> pc == $past(tmp));

  // R9
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(pc) && $stable(src) && $stable(dst) && $stable(tmp)));
endmodule

// File: rtl/movecore_top.sv
module movecore_top #(
  parameter int DW   = mc_pkg::WORD_W,
  parameter int IDXW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] ld_rdata,
  output logic [DW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_src,
  output logic [DW-1:0] dbg_dst,
  output logic [DW-1:0] dbg_tmp,
  output logic          dbg_wr
);
  localparam int NRD = 4;
  localparam int P_I0 = 0;
  localparam int P_I1 = 1;
  localparam int P_OP = 2;
  localparam int P_LD = 3;

  logic               freeze;
  logic               primed;
  logic               wr_stb;
  logic               take_br;
  logic [DW-1:0]      pc, src, dst, tmp;
  logic [NRD-1:0][DW-1:0] ra, rd;
  logic               mem_we;
  logic [DW-1:0]      mem_wa, mem_wd;

  assign freeze = halt | ld_en;

  assign ra[P_I0] = pc;
  assign ra[P_I1] = pc + DW'(1);
  assign ra[P_OP] = src;
  assign ra[P_LD] = ld_addr;

  assign mem_we = wr_stb | ld_en;
  assign mem_wa = ld_en ? ld_addr : dst;
  assign mem_wd = ld_en ? ld_data : tmp;

  mc_mem #(.DW(DW), .IDXW(IDXW), .NRD(NRD)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .raddr (ra),
    .rdata (rd),
    .we    (mem_we),
    .waddr (mem_wa),
    .wdata (mem_wd)
  );

  mc_seq #(.DW(DW), .PRIME(2)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .freeze  (freeze),
    .dst     (dst),
    .primed  (primed),
    .wr_stb  (wr_stb),
    .take_br (take_br)
  );

  mc_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .adv     (~freeze),
    .take_br (take_br),
    .f_src   (rd[P_I0]),
    .f_dst   (rd[P_I1]),
    .m_src   (rd[P_OP]),
    .pc      (pc),
    .src     (src),
    .dst     (dst),
    .tmp     (tmp)
  );

  assign ld_rdata = rd[P_LD];
  assign dbg_pc   = pc;
  assign dbg_src  = src;
  assign dbg_dst  = dst;
  assign dbg_tmp  = tmp;
  assign dbg_wr   = wr_stb;

  // R1
  prime_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dbg_wr);
endmodule

// File: tb/test_movecore_top.sv
`timescale 1ns/1ps
module test_movecore_top;
  localparam int DW = 16;
  localparam int IDXW = 8;
  localparam logic [DW-1:0] JMP = 16'hFFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          halt = 1'b1;
  logic          ld_en = 1'b0;
  logic [DW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] ld_rdata, dbg_pc, dbg_src, dbg_dst, dbg_tmp;
  logic          dbg_wr;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  movecore_top #(.DW(DW), .IDXW(IDXW)) i_movecore_top (
    .clk(clk), .rst(rst), .halt(halt), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_rdata(ld_rdata),
    .dbg_pc(dbg_pc), .dbg_src(dbg_src), .dbg_dst(dbg_dst),
    .dbg_tmp(dbg_tmp), .dbg_wr(dbg_wr)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge with halt high.
  task automatic do_reset();
    rst = 1'b1; halt = 1'b1; ld_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic poke(input logic [DW-1:0] a, input logic [DW-1:0] v);
    ld_addr = a; ld_data = v; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input logic [DW-1:0] a, output logic [DW-1:0] v);
    ld_addr = a;
    #1;
    v = ld_rdata;
  endtask

  task automatic wipe();
    for (int i = 0; i < (1 << IDXW); i++) poke(DW'(i), '0);
  endtask

  task automatic step(output logic w, output logic [DW-1:0] d, output logic [DW-1:0] t);
    halt = 1'b0;
    #1;
    w = dbg_wr; d = dbg_dst; t = dbg_tmp;
    @(negedge clk);
    halt = 1'b1;
  endtask

  task automatic test_reset_fetch();
    logic w; logic [DW-1:0] d, t, v;
    wipe();
    poke(0, 16'h0005); poke(1, 16'h0006); poke(2, 16'h0007); poke(3, 16'h0008);
    poke(5, 16'h1111); poke(6, 16'hAAAA); poke(7, 16'h2222);
    do_reset();
    chk("R1 pc", dbg_pc, 0); chk("R1 src", dbg_src, 0);
    chk("R1 dst", dbg_dst, 0); chk("R1 tmp", dbg_tmp, 0);
    step(w, d, t);
    chk("R1 no write step1", {15'd0, w}, 0);
    chk("R2 pc", dbg_pc, 2); chk("R2 src", dbg_src, 5); chk("R2 dst", dbg_dst, 6);
    step(w, d, t);
    chk("R1 no write step2", {15'd0, w}, 0);
    chk("R3 tmp", dbg_tmp, 16'h1111); chk("R2 pc2", dbg_pc, 4);
    chk("R2 src2", dbg_src, 7); chk("R2 dst2", dbg_dst, 8);
    peek(6, v); chk("R1 unwritten", v, 16'hAAAA);
    step(w, d, t);
    chk("R4 strobe", {15'd0, w}, 1); chk("R4 addr", d, 8);
    peek(8, v); chk("R4 stored", v, 16'h1111);
    chk("R3 tmp2", dbg_tmp, 16'h2222);
  endtask

  task automatic test_halt();
    logic [DW-1:0] p, s, d, t, v;
    p = dbg_pc; s = dbg_src; d = dbg_dst; t = dbg_tmp;
    peek(d, v);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 no strobe", {15'd0, dbg_wr}, 0);
    end
    chk("R9 pc", dbg_pc, p); chk("R9 src", dbg_src, s);
    chk("R9 dst", dbg_dst, d); chk("R9 tmp", dbg_tmp, t);
    peek(d, t); chk("R9 mem", t, v);
  endtask

  task automatic test_load_freeze();
    logic [DW-1:0] p, v;
    p = dbg_pc;
    halt = 1'b0; ld_addr = 16'h0050; ld_data = 16'h9999; ld_en = 1'b1;
    #1;
    chk("R10 no core write", {15'd0, dbg_wr}, 0);
    @(negedge clk);
    ld_en = 1'b0; halt = 1'b1;
    chk("R10 pc frozen", dbg_pc, p);
    peek(16'h0050, v); chk("R10 loaded", v, 16'h9999);
  endtask

  task automatic test_subtract();
    localparam logic [DW-1:0] B = 16'h30, C = 16'h31, ACC = 16'h32, SUB = 16'h33;
    localparam logic [DW-1:0] X = 16'h34, Y = 16'h35, Z = 16'h36, A = 16'h37;
    logic w; logic [DW-1:0] d, t, a, v;
    int nsub = 0;
    wipe();
    poke(0, B); poke(1, X); poke(2, C); poke(3, ACC); poke(4, Y);
    poke(5, SUB); poke(6, ACC); poke(7, Y); poke(8, Z); poke(9, A);
    poke(B, 16'd1000); poke(C, 16'd250);
    do_reset();
    for (int i = 0; i < 6; i++) begin
      step(w, d, t);
      // memory-mapped subtract unit: a store to SUB decrements ACC
      if (w && d == SUB) begin
        peek(ACC, a);
        poke(ACC, a - t);
        nsub++;
      end
    end
    chk("R5 subtract fired once", DW'(nsub), 1);
    peek(A, v); chk("R5 A = B - C", v, 16'd750);
    peek(ACC, v); chk("R5 acc", v, 16'd750);
  endtask

  task automatic test_branch();
    logic w; logic [DW-1:0] d, t, v;
    wipe();
    poke(0, 16'h20); poke(1, 16'h34); poke(2, 16'h35); poke(3, JMP);
    poke(4, 16'h21); poke(5, 16'h38); poke(6, 16'h22); poke(7, 16'h39);
    poke(16'h20, 16'h40); poke(16'h21, 16'h5555); poke(16'h22, 16'h6666);
    poke(16'h23, 16'h7777); poke(16'h35, 16'h1234);
    poke(16'h40, 16'h23); poke(16'h41, 16'h3A); poke(16'hFF, 16'hBEEF);
    do_reset();
    step(w, d, t); step(w, d, t);
    step(w, d, t);
    chk("R6 no strobe on jump", {15'd0, w}, 0);
    chk("R6 pc = target", dbg_pc, 16'h40);
    chk("R7 delay slot fetched", dbg_dst, 16'h38);
    peek(16'hFF, v); chk("R6 no store at all-ones", v, 16'hBEEF);
    step(w, d, t);
    chk("R7 delay slot stores", {15'd0, w}, 1);
    chk("R7 pc after slot", dbg_pc, 16'h42);
    chk("R7 target fetched", dbg_src, 16'h23);
    peek(16'h38, v); chk("R7 slot result", v, 16'h1234);
    step(w, d, t);
    peek(16'h3A, v); chk("R7 target result", v, 16'h5555);
    peek(16'h39, v); chk("R7 skipped insn", v, 16'h0000);
  endtask

  task automatic test_same_cycle();
    logic w; logic [DW-1:0] d, t, v;
    // store and TMP load hit the same word
    wipe();
    poke(0, 16'h30); poke(1, 16'h40); poke(2, 16'h31); poke(3, 16'h31);
    poke(16'h30, 16'hAAAA); poke(16'h31, 16'hBBBB);
    do_reset();
    repeat (3) step(w, d, t);
    chk("R8 tmp sees old word", dbg_tmp, 16'hBBBB);
    peek(16'h31, v); chk("R4 new word stored", v, 16'hAAAA);
    // store hits the word fetched as next DST
    wipe();
    poke(0, 16'h30); poke(1, 16'h40); poke(2, 16'h41); poke(3, 16'h05);
    poke(4, 16'h42); poke(5, 16'h43); poke(16'h30, 16'hAAAA);
    do_reset();
    repeat (3) step(w, d, t);
    chk("R8 fetch sees old word", dbg_dst, 16'h43);
    peek(5, v); chk("R8 fetch word overwritten", v, 16'hAAAA);
  endtask

  initial begin
    @(negedge clk);
    test_reset_fetch();
    test_halt();
    test_load_freeze();
    test_subtract();
    test_branch();
    test_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(100000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule